// File: doc/BRIEF.md
# Two-Wire Serial Register Access Slave

This block is a small slave for the common two-wire serial bus (I2C) that gives a host read and write access to an external byte-wide register file. It oversamples the clock and data lines with the system clock and finds START and STOP conditions on them. It answers one fixed 7-bit device address. A write message carries a register pointer byte and then any number of data bytes. Each data byte is written at the pointer, and the pointer then moves on to the next register.

A read message returns bytes starting at the current pointer, most significant bit first. The pointer advances after each byte. The master acknowledges each byte to ask for another, and a not-acknowledge ends the read. The slave takes SCL only as an input and never holds it low. It pulls SDA low for its acknowledge bits and for zero read bits. At all other times it releases SDA.

The register file sits outside the block. It sees an address, write data and a one-cycle write strobe, and it returns read data for the presented address in the same cycle.

Top module: `i2c_regs_slave`

## Requirements
- R1: The device address is 7'h34, so the address byte is 8'h68 for a write and 8'h69 for a read. A matching address byte is acknowledged by driving SDA low during the ninth clock.
- R2: START (SDA falling while SCL is high) begins a new message from any state, including a repeated START. STOP (SDA rising while SCL is high) returns the block to idle and drops a partly received byte without writing anything.
- R3: In a write message, the first byte after the address is acknowledged and loaded into the register pointer. It causes no register write.
- R4: Each further byte of a write message is acknowledged and written with a single-cycle strobe to the register at the pointer. The pointer then advances by one.
- R5: A read message shifts out, MSB first, the register at the pointer, and the pointer advances by one after each byte. The pointer is kept from an earlier message, so a read may follow a STOP.
- R6: When the master acknowledges a read byte (SDA low in the ninth clock), the next byte follows. When the master does not acknowledge, the slave leaves SDA released until the next START or STOP.
- R7: After an address byte that does not match, the slave gives no acknowledge, drives nothing and writes nothing until the next START or STOP.
- R8: The SDA drive changes only while the synchronized SCL is low. After reset and in idle, SDA is released.
- R9: Transfers work at both the 100 kbit/s and the 400 kbit/s bus rates. For this, the system clock must give at least about 20 samples per SCL high or low phase.
- R10: The register pointer wraps from its highest value to zero, for writes and for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | AW | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register file content at reg_addr |

## Verification
Every result of the block trails the SCL edge that causes it by about three system clocks: two for the synchronizer and one for the state register. The ACK and read-data drive follow an SCL fall by that delay, and the write strobe follows the falling edge of the eighth data bit by the same delay. The master model therefore samples SDA a full quarter bit after it raises SCL, well past that delay. It changes SDA only a quarter bit after SCL falls. A scoreboard queue holds the expected register writes. A monitor sampling on the falling system-clock edge pops and compares each strobe as it appears, and it flags any strobe that arrives when nothing is expected.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_o
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], line_i[g]};
    end

    // idle bus level is high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign line_o[g] = chain_q[LAST];
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_prev_q;
  logic sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise = !scl_prev_q && scl_s;
    scl_fall = scl_prev_q && !scl_s;
    start_ev = scl_prev_q && scl_s && sda_prev_q && !sda_s;
    stop_ev  = scl_prev_q && scl_s && !sda_prev_q && sda_s;
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev, scl_rise}) && $onehot0({start_ev, stop_ev, scl_fall})); // R2
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         AW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam int          CNT_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [AW-1:0]    PTR_ONE  = AW'(1);

  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              full_q, full_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              we_q, we_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic              load_q, load_d;
  logic              rx_state;

  always_comb begin
    rx_state = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WR);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    full_d  = full_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    ptr_d   = ptr_q;
    we_d    = 1'b0;
    wdata_d = wdata_q;
    load_d  = 1'b0;

    if (stop_ev) begin
      state_d = ST_IDLE;
      full_d  = 1'b0;
      cnt_d   = '0;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      full_d  = 1'b0;
      cnt_d   = '0;
    end else if (rx_state) begin
      if (scl_rise && !full_q) begin
        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) full_d = 1'b1;
      end else if (scl_fall && full_q) begin
        full_d = 1'b0;
        cnt_d  = '0;
        unique case (state_q)
          ST_ADDR: begin
            if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
              state_d = ST_ADDR_ACK;
              rw_d    = sh_q[0];
            end else begin
              state_d = ST_SKIP;
            end
          end
          ST_PTR: begin
            state_d = ST_PTR_ACK;
            ptr_d   = sh_q[AW-1:0];
            load_d  = 1'b1;
          end
          default: begin
            state_d = ST_WR_ACK;
            we_d    = 1'b1;
            wdata_d = sh_q;
          end
        endcase
      end
    end else begin
      unique case (state_q)
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_d = ST_RD;
              sh_d    = reg_rdata;
              cnt_d   = '0;
            end else begin
              state_d = ST_PTR;
            end
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall) state_d = ST_WR;
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_d = ST_WR;
            ptr_d   = ptr_q + PTR_ONE;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              state_d = ST_RD_ACK;
              ptr_d   = ptr_q + PTR_ONE;
              cnt_d   = '0;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = !sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RD;
              sh_d    = reg_rdata;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      full_q  <= full_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      ptr_q   <= ptr_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
      load_q  <= load_d;
    end
  end

  always_comb begin
    sda_oe = (state_q == ST_ADDR_ACK) || (state_q == ST_PTR_ACK) ||
             (state_q == ST_WR_ACK)   || ((state_q == ST_RD) && !sh_q[BYTE_W-1]);
  end

  assign reg_addr  = ptr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R4

  AST_WE_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (state_q == ST_WR_ACK) && sda_oe); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) && !load_q |-> ptr_q == AW'($past(ptr_q) + PTR_ONE)); // R10

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !sda_oe && !reg_we); // R7
endmodule

// File: rtl/i2c_regs_slave.sv
module i2c_regs_slave
  import i2c_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h34,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] lines_s;
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i ({sda_i, scl_i}),
    .line_o (lines_s)
  );

  assign scl_s = lines_s[0];
  assign sda_s = lines_s[1];

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R8
endmodule

// File: tb/i2c_regs_slave_tb_top.sv
module i2c_regs_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q_FAST     = 62;
  localparam int Q_SLOW     = 250;
  localparam int WD_CYCLES  = 190000;

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic       sda_oe;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       sda_bus;

  logic [7:0]  regfile [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] exp_q [$];

  int n_tests = 0;
  int n_fail  = 0;
  int qtr     = Q_FAST;

  assign sda_bus = sda_m & ~sda_oe;
  assign reg_rdata = regfile[reg_addr];

  i2c_regs_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (reg_we) regfile[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every write strobe must match the next queued expectation
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R7 unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({reg_addr, reg_wdata} == e, "R4 write", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic wq();
    repeat (qtr) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_bus; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!ack);
  endtask

  // driver: write message, queue the expected register writes
  task automatic wr_msg(input logic [7:0] ptr, input logic [7:0] d [], input string req);
    bit a;
    logic [7:0] p;
    bus_start();
    put_byte(8'h68, a); check(a, "R1 write address ack", a, 1);
    put_byte(ptr, a);   check(a, "R3 pointer ack", a, 1);
    p = ptr;
    foreach (d[i]) begin
      exp_q.push_back({p, d[i]});
      exp_mem[p] = d[i];
      put_byte(d[i], a); check(a, req, a, 1);
      p = p + 8'd1;
    end
    bus_stop();
    check(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
  endtask

  // read n bytes starting at ptr through a repeated START
  task automatic rd_msg(input logic [7:0] ptr, input int n, input string req);
    bit a;
    logic [7:0] v;
    logic [7:0] p;
    bus_start();
    put_byte(8'h68, a); check(a, "R1 write address ack", a, 1);
    put_byte(ptr, a);   check(a, "R3 pointer ack", a, 1);
    bus_start();
    put_byte(8'h69, a); check(a, "R1 read address ack", a, 1);
    p = ptr;
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, v);
      check(v == exp_mem[p], req, v, exp_mem[p]);
      p = p + 8'd1;
    end
    get_bit(a);
    check(a == 1'b1, "R6 released after master nack", a, 1);
    bus_stop();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      regfile[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    scl_m = 1'b1;
    sda_m = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0 && reg_we == 1'b0, "R8 reset state", sda_oe, 0);

    // R4: burst write then R5 burst read through a repeated START
    wr_msg(8'h10, '{8'hA5, 8'h3C, 8'h7E}, "R4 data ack");
    rd_msg(8'h10, 3, "R5 read data");

    // R7: foreign address 0x35 (byte 0x6A) is neither acked nor written
    bus_start();
    put_byte(8'h6A, a); check(!a, "R7 no ack on foreign address", a, 0);
    put_byte(8'h10, a); check(!a, "R7 no ack after mismatch", a, 0);
    put_byte(8'h00, a); check(!a, "R7 no ack after mismatch", a, 0);
    bus_stop();
    rd_msg(8'h10, 1, "R7 register untouched");

    // R2: STOP in the middle of a data byte drops it
    bus_start();
    put_byte(8'h68, a); check(a, "R1 write address ack", a, 1);
    put_byte(8'h20, a); check(a, "R3 pointer ack", a, 1);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    check(sda_oe == 1'b0, "R2 idle after aborted byte", sda_oe, 0);
    rd_msg(8'h20, 1, "R2 aborted byte not written");

    // R10: pointer wrap on write and on read
    wr_msg(8'hFE, '{8'h11, 8'h22, 8'h33}, "R10 wrap write ack");
    rd_msg(8'hFE, 3, "R10 wrap read");

    // R5: pointer kept across messages; read directly after a STOP
    wr_msg(8'h40, '{}, "R3");
    bus_start();
    put_byte(8'h69, a); check(a, "R1 read address ack", a, 1);
    get_byte(1'b1, v); check(v == exp_mem[8'h40], "R5 pointer kept", v, exp_mem[8'h40]);
    get_byte(1'b0, v); check(v == exp_mem[8'h41], "R6 ack continues read", v, exp_mem[8'h41]);
    bus_stop();

    // R9: slow bus rate
    qtr = Q_SLOW;
    wr_msg(8'h50, '{8'h96}, "R9 slow write ack");
    rd_msg(8'h50, 1, "R9 slow read");
    qtr = Q_FAST;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule